// File: doc/BRIEF.md
# DRAM Timing Register with Update Guard

This block holds the timing codes that a DRAM sequencer uses: a two-bit random-cycle count code, a RAS-to-CAS delay select and a two-bit RAS precharge code. They sit in one host-writable byte. Changing a live timing value while the memory is busy could corrupt an access. The block therefore computes an `update_ok` status. It is true when the display engine is idle: the display FIFO is off, the half-frame buffer is off and the ink/cursor mode is zero. It is also true when neither display enable has been set at any point since reset. A write that would put a new non-zero timing value in place is accepted only while `update_ok` is true. Otherwise it is dropped and `wr_err` is raised.

The block also times DRAM random cycles for the sequencer. A start presented on `cyc_start` while `cyc_ready` is high begins a count of N = count code + `RC_BASE` clock cycles, and `cyc_done` pulses when the count ends. The start strobe has no back-pressure. A start presented while `cyc_ready` is low is dropped, not queued, so the sequencer must hold off until `cyc_ready` returns high.

Top module: `dram_timing_guard`

## Requirements
- R1: Read data bit 7 and bits 1:0 always read 0, and write data in those positions has no effect. The stored timing fields occupy write/read bits 6:2: count code in bits 6:5, delay select in bit 4, precharge code in bits 3:2.
- R2: A write (`host_wr` high at a clock edge) that is accepted stores write bits 6:2, and they appear on `host_rdata` and the timing outputs after that edge.
- R3: A write whose bits 6:2 are all zero, or equal the stored fields, is always accepted and clears `wr_err`.
- R4: Any other write made while `update_ok` is low leaves the stored fields unchanged and sets `wr_err` after that edge. Any accepted write clears `wr_err`.
- R5: A sticky "display used" flag sets at the first clock edge where any `disp_en` bit is 1 and clears only on reset. While it is clear and `disp_en` is all zero, `update_ok` is high regardless of the idle inputs.
- R6: `update_ok` is high whenever `fifo_off` and `hfb_off` are both 1 and `ink_mode` is 0, and low when that idle condition fails while displays have been used.
- R7: After a start accepted at edge k, `cyc_done` is high for exactly one cycle, following edge k+N, where N = count code + `RC_BASE` and the count code is taken at edge k.
- R8: `cyc_ready` is low from the edge after an accepted start through the edge that raises `cyc_done`. A start presented while it is low is ignored.
- R9: After reset the stored fields are 0, `wr_err` is 0, `cyc_ready` is 1, `cyc_done` is 0 and the sticky flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data |
| wr_err | output | 1 | Last write was rejected by the guard |
| disp_en | input | DISP_W (2) | Display enable bits |
| fifo_off | input | 1 | Display FIFO disabled |
| hfb_off | input | 1 | Half-frame buffer disabled |
| ink_mode | input | INK_W (2) | Ink/cursor mode, 0 = inactive |
| update_ok | output | 1 | Timing change is safe now |
| tm_rc_code | output | 2 | Random-cycle count code |
| tm_rcd | output | 1 | RAS-to-CAS delay select |
| tm_rp_code | output | 2 | RAS precharge code |
| cyc_start | input | 1 | Start a random-cycle count (valid) |
| cyc_ready | output | 1 | Counter idle, start will be accepted |
| cyc_done | output | 1 | One-cycle pulse at the end of the count |

## Verification
The hardest situation to reach is a restricted write arriving after the displays have been used, while the idle condition is false. It needs a display enable pulse first to set the sticky flag, then a write whose fields are non-zero and differ from the stored value. The stimulus pulses `disp_en` once, drops `fifo_off`, and tries both restricted writes and harmless ones (zero and same value). It then resets in the middle of a random run, to show that the never-used path reopens the guard. A second start held through the busy window checks that the done pulse keeps the timing of the first start.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int REG_W      = 8;
  localparam int RC_LSB     = 5;
  localparam int RCD_BIT    = 4;
  localparam int RP_LSB     = 2;
  localparam int CODE_W     = 2;
  localparam logic [REG_W-1:0] FIELD_MASK = 8'h7C;

  typedef struct packed {
    logic [CODE_W-1:0] rc;
    logic              rcd;
    logic [CODE_W-1:0] rp;
  } dtg_timing_t;

  function automatic dtg_timing_t unpack_timing(input logic [REG_W-1:0] b);
    dtg_timing_t t;
    t.rc  = b[RC_LSB +: CODE_W];
    t.rcd = b[RCD_BIT];
    t.rp  = b[RP_LSB +: CODE_W];
    return t;
  endfunction
endpackage

// File: rtl/dtg_guard.sv
module dtg_guard #(
  parameter int DISP_W = 2,
  parameter int INK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DISP_W-1:0] disp_en,
  input  logic              fifo_off,
  input  logic              hfb_off,
  input  logic [INK_W-1:0]  ink_mode,
  output logic              update_ok
);
  logic used_q;
  logic engine_idle;
  logic never_used;

  // sticky record of any display enable since reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          used_q <= 1'b0;
    else if (|disp_en)   used_q <= 1'b1;
  end

  always_comb begin
    engine_idle = fifo_off && hfb_off && (ink_mode == '0);
    never_used  = !used_q && (disp_en == '0);
    update_ok   = engine_idle || never_used;
  end

  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    used_q |=> used_q);

  p_fresh_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!used_q && disp_en == '0) |-> update_ok);

  p_busy_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q && !fifo_off) |-> !update_ok);
endmodule

// File: rtl/dtg_regfile.sv
module dtg_regfile
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             update_ok,
  output logic [REG_W-1:0] rdata,
  output dtg_timing_t      timing,
  output logic             wr_err
);
  logic [REG_W-1:0] store_q;
  logic [REG_W-1:0] incoming;
  logic             restricted;
  logic             accept;

  always_comb begin
    incoming   = wdata & FIELD_MASK;
    restricted = (incoming != '0) && (incoming != store_q);
    accept     = wr && (!restricted || update_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      wr_err  <= 1'b0;
    end else if (wr) begin
      if (accept) begin
        store_q <= incoming;
        wr_err  <= 1'b0;
      end else begin
        wr_err  <= 1'b1;
      end
    end
  end

  assign rdata  = store_q;
  assign timing = unpack_timing(store_q);

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && restricted && !update_ok) |=> ($stable(store_q) && wr_err));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && update_ok) |=> (store_q == $past(wdata & FIELD_MASK)));

  p_free_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !restricted) |=> !wr_err);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(store_q));
endmodule

// File: rtl/dtg_rc_counter.sv
module dtg_rc_counter #(
  parameter int CODE_W  = 2,
  parameter int RC_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              ready,
  output logic              done
);
  localparam int MAX_N = RC_BASE + (1 << CODE_W) - 1;
  localparam int CNT_W = $clog2(MAX_N + 1) + 1;

  logic             busy_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy_q) begin
        if (left_q == '0) begin
          done   <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        left_q <= CNT_W'(code) + CNT_W'(RC_BASE - 1);
      end
    end
  end

  assign ready = !busy_q;

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> (!ready && left_q == CNT_W'($past(code)) + CNT_W'(RC_BASE - 1)));

  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && !$past(ready)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && left_q != '0) |=> (!ready && !done && left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard #(
  parameter int DISP_W  = 2,
  parameter int INK_W   = 2,
  parameter int RC_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              wr_err,
  input  logic [DISP_W-1:0] disp_en,
  input  logic              fifo_off,
  input  logic              hfb_off,
  input  logic [INK_W-1:0]  ink_mode,
  output logic              update_ok,
  output logic [1:0]        tm_rc_code,
  output logic              tm_rcd,
  output logic [1:0]        tm_rp_code,
  input  logic              cyc_start,
  output logic              cyc_ready,
  output logic              cyc_done
);
  import dtg_pkg::*;

  dtg_timing_t timing;
  logic        guard_ok;

  dtg_guard #(.DISP_W(DISP_W), .INK_W(INK_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .fifo_off(fifo_off),
    .hfb_off(hfb_off), .ink_mode(ink_mode), .update_ok(guard_ok)
  );

  dtg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_wdata),
    .update_ok(guard_ok), .rdata(host_rdata), .timing(timing), .wr_err(wr_err)
  );

  dtg_rc_counter #(.CODE_W(CODE_W), .RC_BASE(RC_BASE)) u_rc (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .code(timing.rc),
    .ready(cyc_ready), .done(cyc_done)
  );

  assign update_ok  = guard_ok;
  assign tm_rc_code = timing.rc;
  assign tm_rcd     = timing.rcd;
  assign tm_rp_code = timing.rp;

  p_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (host_rdata[7] == 1'b0 && host_rdata[1:0] == 2'b00));
endmodule

// File: tb/dram_timing_guard_test.sv
module dram_timing_guard_test;
  localparam int RC_BASE = 2;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0;
  logic [7:0] host_wdata = 0;
  logic [1:0] disp_en = 0, ink_mode = 0;
  logic fifo_off = 0, hfb_off = 0, cyc_start = 0;
  logic [7:0] host_rdata;
  logic wr_err, update_ok, tm_rcd, cyc_ready, cyc_done;
  logic [1:0] tm_rc_code, tm_rp_code;

  int checks = 0, errors = 0;

  dram_timing_guard #(.DISP_W(2), .INK_W(2), .RC_BASE(RC_BASE)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .wr_err(wr_err), .disp_en(disp_en),
    .fifo_off(fifo_off), .hfb_off(hfb_off), .ink_mode(ink_mode),
    .update_ok(update_ok), .tm_rc_code(tm_rc_code), .tm_rcd(tm_rcd),
    .tm_rp_code(tm_rp_code), .cyc_start(cyc_start), .cyc_ready(cyc_ready),
    .cyc_done(cyc_done)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int m_fld, cyc_i, m_due;
  bit m_err, m_used, m_done;

  function automatic bit model_ok();
    return (fifo_off && hfb_off && ink_mode == 0) || (!m_used && disp_en == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fld = 0; m_err = 0; m_used = 0; cyc_i = 0; m_due = -1; m_done = 0;
    end else begin
      int nf, n;
      bit ok;
      nf = (host_wdata >> 2) & 31;
      ok = model_ok();
      n  = (m_fld >> 3) + RC_BASE;
      cyc_i++;
      m_done = (m_due == cyc_i);
      if (cyc_start && m_due < cyc_i) m_due = cyc_i + n;
      if (host_wr) begin
        if (nf == 0 || nf == m_fld || ok) begin m_fld = nf; m_err = 0; end
        else m_err = 1;
      end
      if (disp_en != 0) m_used = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2 rdata", host_rdata, m_fld << 2);
    chk("R2 rc_code", tm_rc_code, m_fld >> 3);
    chk("R2 rcd", tm_rcd, (m_fld >> 2) & 1);
    chk("R2 rp_code", tm_rp_code, m_fld & 3);
    chk("R4 wr_err", wr_err, m_err);
    chk("R6 update_ok", update_ok, model_ok());
    chk("R7 cyc_done", cyc_done, m_done);
    chk("R8 cyc_ready", cyc_ready, m_due <= cyc_i);
  end

  task automatic step();
    @(posedge clk); @(negedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] d);
    host_wr = 1; host_wdata = d; step(); host_wr = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst_n = 1; step();
    // R9 reset state
    chk("R9 rdata", host_rdata, 0); chk("R9 wr_err", wr_err, 0);
    chk("R9 ready", cyc_ready, 1); chk("R9 done", cyc_done, 0);
    chk("R9 never used opens guard", update_ok, 1);

    // R1 reserved bits, R2 store
    wr(8'hFF);
    chk("R1 reserved read zero", host_rdata, 8'h7C);
    chk("R2 rc_code", tm_rc_code, 3);

    // R7/R8 counter, N = 3 + RC_BASE = 5
    cyc_start = 1; step();
    step(); cyc_start = 0;
    chk("R8 busy not ready", cyc_ready, 0);
    for (int i = 2; i < 5; i++) begin step(); chk("R7 no early done", cyc_done, 0); end
    step(); chk("R7 done after N", cyc_done, 1);
    step(); chk("R7 done one cycle", cyc_done, 0); chk("R8 ready again", cyc_ready, 1);

    // R5 sticky flag
    disp_en = 2'b01; step(); disp_en = 0; step();
    chk("R5 sticky closes guard", update_ok, 0);

    // R3/R4
    wr(8'h00); chk("R3 zero accepted", host_rdata, 0); chk("R3 err clear", wr_err, 0);
    wr(8'h10); chk("R4 rejected hold", host_rdata, 0); chk("R4 err set", wr_err, 1);
    wr(8'h83); chk("R3 reserved-only is zero", wr_err, 0);

    // R6 idle condition
    fifo_off = 1; hfb_off = 1; ink_mode = 0; step();
    chk("R6 idle opens", update_ok, 1);
    wr(8'h24); chk("R2 idle write", host_rdata, 8'h24);
    ink_mode = 2'b01; step(); chk("R6 ink closes", update_ok, 0);
    wr(8'h48); chk("R4 rejected", host_rdata, 8'h24); chk("R4 err", wr_err, 1);
    wr(8'h24); chk("R3 same value", wr_err, 0);

    // random phase with a reset in the middle
    for (int i = 0; i < 3000; i++) begin
      if (i == 1500) begin
        rst_n = 0; step(); step(); rst_n = 1;
        fifo_off = 0; disp_en = 0; host_wr = 0; cyc_start = 0; step();
        chk("R5 reset reopens guard", update_ok, 1);
        wr(8'h40); chk("R5 write while never used", host_rdata, 8'h40);
      end
      host_wr    = ($urandom % 4) == 0;
      host_wdata = 8'($urandom);
      disp_en    = (i > 1600 && ($urandom % 32) == 0) ? 2'($urandom) : 2'b00;
      fifo_off   = ($urandom % 3) != 0;
      hfb_off    = ($urandom % 4) != 0;
      ink_mode   = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      cyc_start  = ($urandom % 3) == 0;
      step();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule